// File: doc/BRIEF.md
# Packed Add/Subtract Unit

This unit performs lane-wise integer arithmetic on two 64-bit operands. One operation code picks both the lane width (8, 16 or 32 bits, or the whole 64-bit word) and the overflow policy. The policy is wrap-around, clamp to the signed range, or clamp to the unsigned range.

Besides add and subtract, the unit also covers these lane-wise operations:
- rounding average
- byte absolute difference
- minimum and maximum
- equal and greater-than compares, which return a full mask per lane

Lane 0 sits in the least significant bits. A carry or borrow never crosses from one lane into the next.

The arithmetic is combinational. A single register stage captures the result when `in_valid` is high, and `out_valid` marks the cycle in which that result is present.

Top module: `simd_addsub_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` is 0 and `result` is 0 until the first accepted operation.
- R2: An operation presented with `in_valid` high appears on `result`, with `out_valid` high, after the next rising clock edge. When `in_valid` is low, `out_valid` falls and `result` keeps its previous value, whatever the operands and operation code are.
- R3: Wrap-around add and subtract work on 8 byte lanes, 4 halfword lanes or 2 word lanes, and also on the full 64-bit word. Each lane keeps only its low bits, and no carry or borrow passes between lanes.
- R4: Signed saturating add and subtract exist for byte and halfword lanes. Byte results clamp to -128..127, and halfword results clamp to -32768..32767.
- R5: Unsigned saturating add and subtract exist for byte and halfword lanes. A sum clamps to 255 or 65535, and a difference below zero gives 0.
- R6: Average on unsigned byte and halfword lanes returns (a + b + 1) >> 1, computed with the carry kept.
- R7: Absolute difference returns |a - b| for each of the 8 unsigned byte lanes.
- R8: Halfword max and min compare lanes as signed values. Byte max and min compare lanes as unsigned values.
- R9: Equal and greater-than compares on byte, halfword and word lanes return all ones in a lane where the condition holds and all zeros otherwise. Greater-than treats the lanes as unsigned.
- R10: The `op_sel` codes are assigned as follows, and codes 29 to 31 give a result of 0.

| Code | Operation |
|------|-----------|
| 0 | wrap add, byte lanes |
| 1 | wrap add, halfword lanes |
| 2 | wrap add, word lanes |
| 3 | wrap add, full 64 bits |
| 4 | signed saturating add, byte lanes |
| 5 | signed saturating add, halfword lanes |
| 6 | unsigned saturating add, byte lanes |
| 7 | unsigned saturating add, halfword lanes |
| 8 | wrap subtract, byte lanes |
| 9 | wrap subtract, halfword lanes |
| 10 | wrap subtract, word lanes |
| 11 | wrap subtract, full 64 bits |
| 12 | signed saturating subtract, byte lanes |
| 13 | signed saturating subtract, halfword lanes |
| 14 | unsigned saturating subtract, byte lanes |
| 15 | unsigned saturating subtract, halfword lanes |
| 16 | average, byte lanes |
| 17 | average, halfword lanes |
| 18 | absolute difference, byte lanes |
| 19 | maximum, halfword lanes |
| 20 | minimum, halfword lanes |
| 21 | maximum, byte lanes |
| 22 | minimum, byte lanes |
| 23 | equal, byte lanes |
| 24 | equal, halfword lanes |
| 25 | equal, word lanes |
| 26 | greater-than, byte lanes |
| 27 | greater-than, halfword lanes |
| 28 | greater-than, word lanes |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op_sel | input | 5 | Operation code (see R10) |
| opnd_a | input | 64 | First operand, lane 0 in the low bits |
| opnd_b | input | 64 | Second operand, lane 0 in the low bits |
| out_valid | output | 1 | `result` holds a newly computed value |
| result | output | 64 | Registered packed result |

## Verification
The bench aims operands at lane values 0x00, 0x01, 0x7F, 0x80, 0x81, 0xFE and 0xFF, and at their halfword equivalents. At those values a wrong overflow test would wrap where it should clamp, or clamp on the wrong side.

Directed cases target specific faults:
- A 0xFF + 0x01 byte add beside a zero neighbour exposes a carry that leaks into the next lane.
- 0x80 against 0x7F exposes a greater-than or byte maximum that compares signed when it should compare unsigned.
- 0xFF averaged with 0xFF exposes an average that drops the ninth bit.
- An idle cycle with changed inputs catches a result register that does not hold its value.

// File: rtl/simd_addsub_unit.sv
`timescale 1ns/1ps
module simd_addsub_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;
  localparam int NW = DATA_W / 32;

  localparam logic [4:0] OP_ADD_B  = 5'd0,  OP_ADD_H  = 5'd1,  OP_ADD_W  = 5'd2,  OP_ADD_D  = 5'd3;
  localparam logic [4:0] OP_ADDS_B = 5'd4,  OP_ADDS_H = 5'd5,  OP_ADDU_B = 5'd6,  OP_ADDU_H = 5'd7;
  localparam logic [4:0] OP_SUB_B  = 5'd8,  OP_SUB_H  = 5'd9,  OP_SUB_W  = 5'd10, OP_SUB_D  = 5'd11;
  localparam logic [4:0] OP_SUBS_B = 5'd12, OP_SUBS_H = 5'd13, OP_SUBU_B = 5'd14, OP_SUBU_H = 5'd15;
  localparam logic [4:0] OP_AVG_B  = 5'd16, OP_AVG_H  = 5'd17, OP_ABSD_B = 5'd18;
  localparam logic [4:0] OP_MAX_H  = 5'd19, OP_MIN_H  = 5'd20, OP_MAX_B  = 5'd21, OP_MIN_B  = 5'd22;
  localparam logic [4:0] OP_CEQ_B  = 5'd23, OP_CEQ_H  = 5'd24, OP_CEQ_W  = 5'd25;
  localparam logic [4:0] OP_CGT_B  = 5'd26, OP_CGT_H  = 5'd27, OP_CGT_W  = 5'd28;

  logic [DATA_W-1:0] add_b, adds_b, addu_b, sub_b, subs_b, subu_b;
  logic [DATA_W-1:0] avg_b, absd_b, max_b, min_b, ceq_b, cgt_b;
  logic [DATA_W-1:0] add_h, adds_h, addu_h, sub_h, subs_h, subu_h;
  logic [DATA_W-1:0] avg_h, max_h, min_h, ceq_h, cgt_h;
  logic [DATA_W-1:0] add_w, sub_w, ceq_w, cgt_w;
  logic [DATA_W-1:0] add_d, sub_d;
  logic [DATA_W-1:0] nxt;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] x, y;
    logic [8:0] s, d;
    assign x = opnd_a[8*i +: 8];
    assign y = opnd_b[8*i +: 8];
    assign s = {1'b0, x} + {1'b0, y};
    assign d = {1'b0, x} - {1'b0, y};

    assign add_b[8*i +: 8]  = s[7:0];
    assign sub_b[8*i +: 8]  = d[7:0];
    assign adds_b[8*i +: 8] = (x[7] == y[7] && s[7] != x[7]) ? (x[7] ? 8'h80 : 8'h7f) : s[7:0];
    assign subs_b[8*i +: 8] = (x[7] != y[7] && d[7] != x[7]) ? (x[7] ? 8'h80 : 8'h7f) : d[7:0];
    assign addu_b[8*i +: 8] = s[8] ? 8'hff : s[7:0];
    assign subu_b[8*i +: 8] = d[8] ? 8'h00 : d[7:0];
    assign avg_b[8*i +: 8]  = s[8:1] + {7'd0, s[0]};
    assign absd_b[8*i +: 8] = d[8] ? (8'd0 - d[7:0]) : d[7:0];
    assign max_b[8*i +: 8]  = d[8] ? y : x;
    assign min_b[8*i +: 8]  = d[8] ? x : y;
    assign ceq_b[8*i +: 8]  = {8{x == y}};
    assign cgt_b[8*i +: 8]  = {8{!d[8] && (x != y)}};

    assert_subu_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_SUBU_B) |=> (result[8*i +: 8] <= $past(opnd_a[8*i +: 8])));

    assert_avg_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_AVG_B) |=>
        ((result[8*i +: 8] >= $past(opnd_a[8*i +: 8]) || result[8*i +: 8] >= $past(opnd_b[8*i +: 8])) &&
         (result[8*i +: 8] <= $past(opnd_a[8*i +: 8]) || result[8*i +: 8] <= $past(opnd_b[8*i +: 8]))));
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    logic [15:0] x, y;
    logic [16:0] s, d;
    logic        slt;
    assign x   = opnd_a[16*i +: 16];
    assign y   = opnd_b[16*i +: 16];
    assign s   = {1'b0, x} + {1'b0, y};
    assign d   = {1'b0, x} - {1'b0, y};
    assign slt = $signed(x) < $signed(y);

    assign add_h[16*i +: 16]  = s[15:0];
    assign sub_h[16*i +: 16]  = d[15:0];
    assign adds_h[16*i +: 16] = (x[15] == y[15] && s[15] != x[15]) ? (x[15] ? 16'h8000 : 16'h7fff) : s[15:0];
    assign subs_h[16*i +: 16] = (x[15] != y[15] && d[15] != x[15]) ? (x[15] ? 16'h8000 : 16'h7fff) : d[15:0];
    assign addu_h[16*i +: 16] = s[16] ? 16'hffff : s[15:0];
    assign subu_h[16*i +: 16] = d[16] ? 16'h0000 : d[15:0];
    assign avg_h[16*i +: 16]  = s[16:1] + {15'd0, s[0]};
    assign max_h[16*i +: 16]  = slt ? y : x;
    assign min_h[16*i +: 16]  = slt ? x : y;
    assign ceq_h[16*i +: 16]  = {16{x == y}};
    assign cgt_h[16*i +: 16]  = {16{!d[16] && (x != y)}};

    assert_adds_pos_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_ADDS_H && !opnd_a[16*i+15] && !opnd_b[16*i+15]) |=> !result[16*i+15]);
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic [31:0] x, y;
    assign x = opnd_a[32*i +: 32];
    assign y = opnd_b[32*i +: 32];
    assign add_w[32*i +: 32] = x + y;
    assign sub_w[32*i +: 32] = x - y;
    assign ceq_w[32*i +: 32] = {32{x == y}};
    assign cgt_w[32*i +: 32] = {32{x > y}};

    assert_cmp_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_CEQ_W || op_sel == OP_CGT_W)) |=>
        (result[32*i +: 32] == 32'd0 || result[32*i +: 32] == {32{1'b1}}));
  end

  assign add_d = opnd_a + opnd_b;
  assign sub_d = opnd_a - opnd_b;

  always_comb begin
    case (op_sel)
      OP_ADD_B:  nxt = add_b;
      OP_ADD_H:  nxt = add_h;
      OP_ADD_W:  nxt = add_w;
      OP_ADD_D:  nxt = add_d;
      OP_ADDS_B: nxt = adds_b;
      OP_ADDS_H: nxt = adds_h;
      OP_ADDU_B: nxt = addu_b;
      OP_ADDU_H: nxt = addu_h;
      OP_SUB_B:  nxt = sub_b;
      OP_SUB_H:  nxt = sub_h;
      OP_SUB_W:  nxt = sub_w;
      OP_SUB_D:  nxt = sub_d;
      OP_SUBS_B: nxt = subs_b;
      OP_SUBS_H: nxt = subs_h;
      OP_SUBU_B: nxt = subu_b;
      OP_SUBU_H: nxt = subu_h;
      OP_AVG_B:  nxt = avg_b;
      OP_AVG_H:  nxt = avg_h;
      OP_ABSD_B: nxt = absd_b;
      OP_MAX_H:  nxt = max_h;
      OP_MIN_H:  nxt = min_h;
      OP_MAX_B:  nxt = max_b;
      OP_MIN_B:  nxt = min_b;
      OP_CEQ_B:  nxt = ceq_b;
      OP_CEQ_H:  nxt = ceq_h;
      OP_CEQ_W:  nxt = ceq_w;
      OP_CGT_B:  nxt = cgt_b;
      OP_CGT_H:  nxt = cgt_h;
      OP_CGT_W:  nxt = cgt_w;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
endmodule

// File: tb/simd_addsub_unit_tb.sv
`timescale 1ns/1ps
module simd_addsub_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  simd_addsub_unit #(.DATA_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  always #2.5 clk = ~clk;

  function automatic string req_of(int op);
    if (op <= 3 || (op >= 8 && op <= 11)) return "R3";
    if (op == 4 || op == 5 || op == 12 || op == 13) return "R4";
    if (op == 6 || op == 7 || op == 14 || op == 15) return "R5";
    if (op == 16 || op == 17) return "R6";
    if (op == 18) return "R7";
    if (op >= 19 && op <= 22) return "R8";
    if (op >= 23 && op <= 28) return "R9";
    return "R10";
  endfunction

  function automatic longint clampv(longint v, longint lo, longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // kinds: 0 add,1 adds,2 addu,3 sub,4 subs,5 subu,6 avg,7 absd,8 maxs,9 mins,10 maxu,11 minu,12 eq,13 gtu
  function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b);
    int w, kind;
    logic [63:0] r, t;
    r = '0;
    if (op == 3) return a + b;
    if (op == 11) return a - b;
    case (op)
      0: begin w = 8;  kind = 0;  end   1: begin w = 16; kind = 0;  end
      2: begin w = 32; kind = 0;  end   4: begin w = 8;  kind = 1;  end
      5: begin w = 16; kind = 1;  end   6: begin w = 8;  kind = 2;  end
      7: begin w = 16; kind = 2;  end   8: begin w = 8;  kind = 3;  end
      9: begin w = 16; kind = 3;  end  10: begin w = 32; kind = 3;  end
      12: begin w = 8;  kind = 4;  end 13: begin w = 16; kind = 4;  end
      14: begin w = 8;  kind = 5;  end 15: begin w = 16; kind = 5;  end
      16: begin w = 8;  kind = 6;  end 17: begin w = 16; kind = 6;  end
      18: begin w = 8;  kind = 7;  end 19: begin w = 16; kind = 8;  end
      20: begin w = 16; kind = 9;  end 21: begin w = 8;  kind = 10; end
      22: begin w = 8;  kind = 11; end 23: begin w = 8;  kind = 12; end
      24: begin w = 16; kind = 12; end 25: begin w = 32; kind = 12; end
      26: begin w = 8;  kind = 13; end 27: begin w = 16; kind = 13; end
      28: begin w = 32; kind = 13; end
      default: return '0;
    endcase
    for (int i = 0; i < 64 / w; i++) begin
      longint m, half, ua, ub, sa, sb, v;
      m    = (longint'(1) << w) - 1;
      half = longint'(1) << (w - 1);
      ua   = longint'(a >> (w * i)) & m;
      ub   = longint'(b >> (w * i)) & m;
      sa   = (ua >= half) ? ua - (m + 1) : ua;
      sb   = (ub >= half) ? ub - (m + 1) : ub;
      case (kind)
        0:  v = ua + ub;
        1:  v = clampv(sa + sb, -half, half - 1);
        2:  v = clampv(ua + ub, 0, m);
        3:  v = ua - ub;
        4:  v = clampv(sa - sb, -half, half - 1);
        5:  v = clampv(ua - ub, 0, m);
        6:  v = (ua + ub + 1) >> 1;
        7:  v = (ua > ub) ? ua - ub : ub - ua;
        8:  v = (sa >= sb) ? ua : ub;
        9:  v = (sa <= sb) ? ua : ub;
        10: v = (ua >= ub) ? ua : ub;
        11: v = (ua <= ub) ? ua : ub;
        12: v = (ua == ub) ? m : 0;
        default: v = (ua > ub) ? m : 0;
      endcase
      t = 64'(v & m);
      r = r | (t << (w * i));
    end
    return r;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(int op, logic [63:0] a, logic [63:0] b, string what);
    @(negedge clk);
    in_valid = 1'b1; op_sel = 5'(op); opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {what, " out_valid"}, {63'd0, out_valid}, 64'd1);
    check(req_of(op), what, result, model(op, a, b));
  endtask

  function automatic logic [63:0] corner_val();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom_range(0, 7))
        0: v[8*i +: 8] = 8'h00;
        1: v[8*i +: 8] = 8'h01;
        2: v[8*i +: 8] = 8'h7f;
        3: v[8*i +: 8] = 8'h80;
        4: v[8*i +: 8] = 8'h81;
        5: v[8*i +: 8] = 8'hfe;
        6: v[8*i +: 8] = 8'hff;
        default: v[8*i +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    #900000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "post-reset result", result, 64'd0);

    // directed corners
    apply(4,  64'h0000_0000_0000_807f, 64'h0000_0000_0000_ff01, "R4 signed byte clamp");
    apply(5,  64'h0000_8000_0000_7fff, 64'h0000_ffff_0000_0001, "R4 signed half clamp");
    apply(12, 64'h0000_0000_0000_7f80, 64'h0000_0000_0000_ff01, "R4 signed byte sub clamp");
    apply(6,  64'h0000_0000_0000_00ff, 64'h0000_0000_0000_0001, "R5 unsigned byte add clamp");
    apply(14, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, "R5 unsigned byte sub floor");
    apply(15, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_ffff, "R5 unsigned half sub floor");
    apply(0,  64'h0000_0000_0000_00ff, 64'h0000_0000_0000_0001, "R3 byte carry isolation");
    apply(2,  64'h0000_0000_ffff_ffff, 64'h0000_0000_0000_0001, "R3 word carry isolation");
    apply(3,  64'h0000_0000_ffff_ffff, 64'h0000_0000_0000_0001, "R3 full add carry");
    apply(16, 64'h0000_0000_0000_ff01, 64'h0000_0000_0000_ff02, "R6 byte average carry");
    apply(17, 64'h0000_0000_0000_ffff, 64'h0000_0000_0000_ffff, "R6 half average carry");
    apply(18, 64'h0000_0000_0000_00ff, 64'h0000_0000_0000_ff00, "R7 absolute difference");
    apply(21, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_007f, "R8 byte max unsigned");
    apply(19, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_7fff, "R8 half max signed");
    apply(26, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_007f, "R9 byte gt unsigned");
    apply(28, 64'h8000_0000_0000_0001, 64'h7fff_ffff_0000_0001, "R9 word gt unsigned");
    apply(23, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, "R9 byte eq all");
    apply(30, 64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0001, "R10 unused code");

    // hold while idle: inputs change, result must not
    apply(1, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040, "R3 half add before idle");
    held = result;
    opnd_a = 64'hdead_beef_dead_beef; opnd_b = 64'h1111_2222_3333_4444; op_sel = 5'd0;
    @(negedge clk);
    check("R2", "idle out_valid", {63'd0, out_valid}, 64'd0);
    check("R2", "idle result hold", result, held);

    // random mix
    for (int it = 0; it < 1200; it++) begin
      int op;
      logic [63:0] a, b;
      op = $urandom_range(0, 31);
      a = ($urandom_range(0, 1) != 0) ? corner_val() : {$urandom, $urandom};
      b = ($urandom_range(0, 1) != 0) ? corner_val() : {$urandom, $urandom};
      if ($urandom_range(0, 9) == 0) b = a;
      apply(op, a, b, "random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule